// File: doc/BRIEF.md
# Quad I/O Flash Read Slave

This block is the serial-bus slave front end of a NOR flash emulator. Everything runs on the serial clock. A transaction starts with a command byte taken from IO0, one bit per clock, MSB first. The block supports three commands:

- **Quad I/O read.** Address, mode and data all travel four bits per clock on IO3..IO0.
- **Single-line read.** Address and data travel one bit per clock.
- **Fixed status read.**

Data bytes come from a synchronous memory read port. The block fetches each byte one clock or more before it is needed, so nibbles and bits stream without gaps across address increments.

A trace strobe carries a one-byte code. It reports each command byte received, the end of the quad address phase and the end of the mode phase. Chip-select high at any clock edge returns the block to command decode and switches off every output enable. When the command is unknown, all output enables stay off, so the host's pull-ups make it read ones.

Top module: `qio_flash_read`

## Requirements
- R1: After reset, ioOe is 0000, memRe is 0 and traceValid is 0.
- R2: While csN is low the command byte is taken from ioIn[0], MSB first, over 8 clocks. It is decoded on the 8th clock edge from the 7 bits already held plus the live ioIn[0]. In the cycle after that edge, traceValid is 1 for exactly one cycle and traceByte equals the command byte. The codes are 0xEB (quad read), 0x03 (single read) and 0x05 (status).
- R3: For 0xEB, the 24-bit address follows over 6 clocks, one nibble per clock on ioIn[3:0], most significant nibble first. After the 6th address clock, traceByte is 0xD2 with a one-cycle traceValid, and a read of that address is requested.
- R4: After the address, a 2-clock mode phase follows. Its value is ignored and it ends with trace code 0xD3. Then comes a 4-clock dummy phase during which ioOe stays 0000.
- R5: After the last dummy clock, ioOe is 1111. Each byte appears on ioOut[3:0] as its high nibble followed by its low nibble, one nibble per clock. Bytes come from consecutive addresses that wrap at 2^24, for as long as csN stays low.
- R6: Memory reads are one-cycle memRe pulses carrying memAddr, and memRe is never high two cycles in a row. memData is expected one clock after the request. The first request goes out with the last address clock. Each later request goes out on the clock that puts a byte's first bits on the pins, and it fetches the following address.
- R7: For 0x03, 24 address bits follow on ioIn[0], MSB first. Two wait clocks follow with ioOe 0000. The data then appears MSB first on ioOut[1] with ioOe 0010, one bit per clock, from consecutive addresses.
- R8: For 0x05, from the clock after the command, ioOut[1] with ioOe 0010 carries the STATUS_BYTE parameter (default 0x9C) MSB first, repeated every 8 clocks.
- R9: An unknown opcode keeps ioOe at 0000 and issues no memory read. The next 8 clocks are assembled and decoded as a new command byte.
- R10: A clock edge with csN high makes ioOe 0000 and memRe 0 in the next cycle. It also returns the block to command decode, so the next clock with csN low carries the MSB of a new command.

Only sequences through recognised commands raise a trace code other than the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; inputs sampled and outputs updated on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| ioIn | input | 4 | Sampled levels of IO3..IO0 |
| ioOut | output | 4 | Values driven on IO3..IO0 when enabled |
| ioOe | output | 4 | Per-pin output enables |
| memRe | output | 1 | One-cycle memory read request |
| memAddr | output | 24 | Memory read address |
| memData | input | 8 | Read data, valid one clock after a request |
| traceValid | output | 1 | One-cycle trace strobe |
| traceByte | output | 8 | Trace code or command byte |

## Verification
On every cycle, the assertions check four things:
- output enables and memory requests drop after any clock with chip-select high;
- the state returns to command decode after such a clock;
- memory requests and trace strobes are single-cycle pulses;
- the quad data counter stays within one byte.

Only the bench's scenarios can show that each nibble and bit reaches the pins in the right clock with the right data. They also show the phase lengths of both read types, memory address sequencing across the 24-bit wrap, and status repetition. Unknown opcodes must leave the pins floating high and be followed by a fresh decode, and the bench shows this too. It also shows that the block recovers cleanly after chip select rises in the middle of an address or data phase, including the address pattern whose last nibble falls from 1111 to 0000.

// File: rtl/qio_pkg.sv
package qio_pkg;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_QADDR,
    ST_MODE,
    ST_DUMMY,
    ST_QDATA,
    ST_SADDR,
    ST_SWAIT,
    ST_SDATA
  } qioState_t;

  localparam logic [2:0] ST_STAT_CODE = 3'd0;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftCmd;
    logic shift1;
    logic shift4;
    logic reqFirst;
    logic loadMem;
    logic loadStatus;
    logic shiftTx;
    logic traceCmd;
    logic traceAddr;
    logic traceMode;
    logic oeOff;
    logic oeSingle;
    logic oeQuad;
  } qioCtl_t;

endpackage

// File: rtl/qio_ctrl.sv
module qio_ctrl
  import qio_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int MODE_CLKS  = 2,
  parameter int DUMMY_CLKS = 4,
  parameter logic [7:0] OP_QUAD   = 8'hEB,
  parameter logic [7:0] OP_SINGLE = 8'h03,
  parameter logic [7:0] OP_STATUS = 8'h05
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic [7:0] cmdNext,
  output qioCtl_t    ctl
);

  localparam int QADDR_CLKS = ADDR_W / 4;
  localparam int MAX_A = (ADDR_W > 8) ? ADDR_W : 8;
  localparam int MAX_B = (MODE_CLKS > DUMMY_CLKS) ? MODE_CLKS : DUMMY_CLKS;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_C + 1);

  qioState_t state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic inStatus, nextInStatus;

  always_comb begin
    ctl          = '0;
    nextState    = state;
    nextCnt      = cnt + CNT_W'(1);
    nextInStatus = inStatus;
    if (csN) begin
      ctl.oeOff    = 1'b1;
      nextState    = ST_CMD;
      nextCnt      = '0;
      nextInStatus = 1'b0;
    end else begin
      unique case (state)
        ST_CMD: begin
          ctl.shiftCmd = 1'b1;
          if (cnt == CNT_W'(7)) begin
            ctl.traceCmd = 1'b1;
            nextCnt = '0;
            if (cmdNext == OP_QUAD) begin
              nextState = ST_QADDR;
            end else if (cmdNext == OP_SINGLE) begin
              nextState = ST_SADDR;
            end else if (cmdNext == OP_STATUS) begin
              nextState      = ST_SDATA;
              nextInStatus   = 1'b1;
              ctl.loadStatus = 1'b1;
              ctl.oeSingle   = 1'b1;
            end
          end
        end
        ST_QADDR: begin
          ctl.shift4 = 1'b1;
          if (cnt == CNT_W'(QADDR_CLKS - 1)) begin
            ctl.reqFirst  = 1'b1;
            ctl.traceAddr = 1'b1;
            nextState = ST_MODE;
            nextCnt   = '0;
          end
        end
        ST_MODE: begin
          if (cnt == CNT_W'(MODE_CLKS - 1)) begin
            ctl.traceMode = 1'b1;
            nextState = ST_DUMMY;
            nextCnt   = '0;
          end
        end
        ST_DUMMY: begin
          if (cnt == CNT_W'(DUMMY_CLKS - 1)) begin
            ctl.loadMem = 1'b1;
            ctl.oeQuad  = 1'b1;
            nextState = ST_QDATA;
            nextCnt   = '0;
          end
        end
        ST_QDATA: begin
          if (cnt == CNT_W'(1)) begin
            ctl.loadMem = 1'b1;
            nextCnt = '0;
          end else begin
            ctl.shiftTx = 1'b1;
          end
        end
        ST_SADDR: begin
          ctl.shift1 = 1'b1;
          if (cnt == CNT_W'(ADDR_W - 1)) begin
            ctl.reqFirst = 1'b1;
            nextState = ST_SWAIT;
            nextCnt   = '0;
          end
        end
        ST_SWAIT: begin
          if (cnt == CNT_W'(1)) begin
            ctl.loadMem  = 1'b1;
            ctl.oeSingle = 1'b1;
            nextState = ST_SDATA;
            nextCnt   = '0;
          end
        end
        ST_SDATA: begin
          if (cnt == CNT_W'(7)) begin
            ctl.loadMem    = !inStatus;
            ctl.loadStatus = inStatus;
            nextCnt = '0;
          end else begin
            ctl.shiftTx = 1'b1;
          end
        end
        default: begin
          nextState = ST_CMD;
          nextCnt   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_CMD;
      cnt      <= '0;
      inStatus <= 1'b0;
    end else begin
      state    <= nextState;
      cnt      <= nextCnt;
      inStatus <= nextInStatus;
    end
  end

  // R10
  cs_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (state == ST_CMD && cnt == '0));

  // R5
  qdata_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_QDATA) |-> (cnt <= CNT_W'(1)));

  // R2
  decode_quad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD && !csN && cnt == CNT_W'(7) && cmdNext == OP_QUAD) |=> (state == ST_QADDR));

  // R9
  unknown_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD && !csN && cnt == CNT_W'(7) && cmdNext != OP_QUAD &&
     cmdNext != OP_SINGLE && cmdNext != OP_STATUS) |=> (state == ST_CMD && cnt == '0));

endmodule

// File: rtl/qio_datapath.sv
module qio_datapath
  import qio_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [7:0] STATUS_BYTE = 8'h9C,
  parameter logic [7:0] TRACE_ADDR  = 8'hD2,
  parameter logic [7:0] TRACE_MODE  = 8'hD3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic [3:0]        ioIn,
  input  qioCtl_t           ctl,
  input  logic [7:0]        memData,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic              memRe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              traceValid,
  output logic [7:0]        traceByte,
  output logic [7:0]        cmdNext
);

  logic [7:0]        cmdShift;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] fullAddr1, fullAddr4;
  logic [7:0]        txReg;
  logic              quadMode;
  logic [3:0]        oeReg;

  assign cmdNext   = {cmdShift[6:0], ioIn[0]};
  assign fullAddr1 = {addrReg[ADDR_W-2:0], ioIn[0]};
  assign fullAddr4 = {addrReg[ADDR_W-5:0], ioIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdShift   <= '0;
      addrReg    <= '0;
      memAddr    <= '0;
      memRe      <= 1'b0;
      txReg      <= '0;
      quadMode   <= 1'b0;
      oeReg      <= '0;
      traceValid <= 1'b0;
      traceByte  <= '0;
    end else begin
      if (ctl.shiftCmd) cmdShift <= cmdNext;
      if (ctl.shift1) addrReg <= fullAddr1;
      else if (ctl.shift4) addrReg <= fullAddr4;

      memRe <= ctl.reqFirst | ctl.loadMem;
      if (ctl.reqFirst) memAddr <= ctl.shift4 ? fullAddr4 : fullAddr1;
      else if (ctl.loadMem) memAddr <= memAddr + ADDR_W'(1);

      if (ctl.loadMem) txReg <= memData;
      else if (ctl.loadStatus) txReg <= STATUS_BYTE;
      else if (ctl.shiftTx) txReg <= quadMode ? {txReg[3:0], 4'h0} : {txReg[6:0], 1'b0};

      if (ctl.oeOff) begin
        oeReg <= 4'b0000;
      end else if (ctl.oeQuad) begin
        oeReg    <= 4'b1111;
        quadMode <= 1'b1;
      end else if (ctl.oeSingle) begin
        oeReg    <= 4'b0010;
        quadMode <= 1'b0;
      end

      traceValid <= ctl.traceCmd | ctl.traceAddr | ctl.traceMode;
      if (ctl.traceCmd) traceByte <= cmdNext;
      else if (ctl.traceAddr) traceByte <= TRACE_ADDR;
      else if (ctl.traceMode) traceByte <= TRACE_MODE;
    end
  end

  assign ioOe  = oeReg;
  assign ioOut = quadMode ? txReg[7:4] : {2'b00, txReg[7], 1'b0};

  // R10
  oe_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (ioOe == 4'b0000 && !memRe));

  // R6
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> !memRe);

  // R2
  trace_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    traceValid |=> !traceValid);

  // R5
  quad_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ioOe[3]) |-> (ioOe == 4'b1111 && $past(traceByte) == TRACE_MODE));

endmodule

// File: rtl/qio_flash_read.sv
module qio_flash_read
  import qio_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int MODE_CLKS  = 2,
  parameter int DUMMY_CLKS = 4,
  parameter logic [7:0] STATUS_BYTE = 8'h9C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic [3:0]        ioIn,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic              memRe,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memData,
  output logic              traceValid,
  output logic [7:0]        traceByte
);

  qioCtl_t    ctl;
  logic [7:0] cmdNext;

  qio_ctrl #(
    .ADDR_W(ADDR_W), .MODE_CLKS(MODE_CLKS), .DUMMY_CLKS(DUMMY_CLKS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .cmdNext(cmdNext), .ctl(ctl)
  );

  qio_datapath #(
    .ADDR_W(ADDR_W), .STATUS_BYTE(STATUS_BYTE)
  ) i_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .ioIn(ioIn), .ctl(ctl),
    .memData(memData), .ioOut(ioOut), .ioOe(ioOe), .memRe(memRe),
    .memAddr(memAddr), .traceValid(traceValid), .traceByte(traceByte),
    .cmdNext(cmdNext)
  );

endmodule

// File: tb/test_qio_flash_read.sv
module test_qio_flash_read;

  localparam logic [7:0] STATUS = 8'h9C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic [3:0] hostDrv = 4'hF;
  logic hostEn = 1'b0;
  logic [3:0] pins, ioOut, ioOe;
  logic memRe, traceValid;
  logic [23:0] memAddr;
  logic [7:0] memData = 8'h00;
  logic [7:0] traceByte;

  int checks = 0;
  int fails = 0;

  logic [3:0] eOe, ePins;
  logic eChk, eTv, eRe;
  logic [7:0] eTb;
  logic [23:0] eRa;

  always #10 clk = ~clk;

  for (genvar g = 0; g < 4; g++) begin : g_pin
    assign pins[g] = ioOe[g] ? ioOut[g] : (hostEn ? hostDrv[g] : 1'b1);
  end

  function automatic logic [7:0] memf(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3C;
  endfunction

  always @(posedge clk) if (memRe) memData <= memf(memAddr);

  qio_flash_read i_qio_flash_read (
    .clk(clk), .rstN(rstN), .csN(csN), .ioIn(pins), .ioOut(ioOut), .ioOe(ioOe),
    .memRe(memRe), .memAddr(memAddr), .memData(memData),
    .traceValid(traceValid), .traceByte(traceByte)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic expIdle();
    eChk = 1'b0; eTv = 1'b0; eRe = 1'b0; eOe = 4'b0000; ePins = 4'hF;
  endtask

  // one clock: inputs already set; compare after the edge
  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    check(ioOe == eOe, tag, "ioOe", int'(ioOe), int'(eOe));
    check(traceValid == eTv, tag, "traceValid", int'(traceValid), int'(eTv));
    if (eTv) check(traceByte == eTb, tag, "traceByte", int'(traceByte), int'(eTb));
    check(memRe == eRe, tag, "memRe", int'(memRe), int'(eRe));
    if (eRe) check(memAddr == eRa, tag, "memAddr", int'(memAddr), int'(eRa));
    if (eChk) check(pins == ePins, tag, "pins", int'(pins), int'(ePins));
    expIdle();
  endtask

  task automatic csHigh(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      csN = 1'b1; hostEn = 1'b0;
      expIdle(); eChk = 1'b1;
      step(tag);
    end
  endtask

  task automatic sendCmd(input logic [7:0] b, input logic [3:0] oeAfter,
                         input logic lastChk, input logic [3:0] lastPins, input string tag);
    for (int i = 7; i >= 0; i--) begin
      csN = 1'b0; hostEn = 1'b1; hostDrv = {3'b111, b[i]};
      expIdle();
      if (i == 0) begin
        eTv = 1'b1; eTb = b; eOe = oeAfter; eChk = lastChk; ePins = lastPins;
      end
      step(tag);
    end
  endtask

  task automatic quadRead(input logic [23:0] a, input int n, input bit cut, input string tag);
    logic [7:0] d;
    sendCmd(8'hEB, 4'b0000, 1'b0, 4'hF, "R2");
    for (int k = 0; k < 6; k++) begin
      hostEn = 1'b1; hostDrv = a[23-4*k -: 4];
      expIdle();
      if (k == 5) begin eTv = 1'b1; eTb = 8'hD2; eRe = 1'b1; eRa = a; end
      step("R3");
    end
    for (int k = 0; k < 2; k++) begin
      hostEn = 1'b1; hostDrv = 4'hF;
      expIdle();
      if (k == 1) begin eTv = 1'b1; eTb = 8'hD3; end
      step("R4");
    end
    for (int k = 0; k < 4; k++) begin
      hostEn = 1'b0;
      expIdle(); eChk = 1'b1;
      if (k == 3) begin
        eOe = 4'hF; ePins = memf(a)[7:4]; eRe = 1'b1; eRa = a + 24'd1;
      end
      step(k == 3 ? "R5" : "R4");
    end
    for (int b = 0; b < n; b++) begin
      d = memf(a + 24'(b));
      if (!(cut && b == n - 1)) begin
        expIdle(); eOe = 4'hF; eChk = 1'b1; ePins = d[3:0];
        step(tag);
      end
      if (b < n - 1) begin
        expIdle(); eOe = 4'hF; eChk = 1'b1;
        ePins = memf(a + 24'(b + 1))[7:4]; eRe = 1'b1; eRa = a + 24'(b + 2);
        step(tag);
      end
    end
  endtask

  task automatic singleRead(input logic [23:0] a, input int n);
    logic [7:0] d;
    sendCmd(8'h03, 4'b0000, 1'b0, 4'hF, "R2");
    for (int i = 23; i >= 0; i--) begin
      hostEn = 1'b1; hostDrv = {3'b111, a[i]};
      expIdle();
      if (i == 0) begin eRe = 1'b1; eRa = a; end
      step("R7");
    end
    hostEn = 1'b0;
    expIdle(); eChk = 1'b1;
    step("R7");
    d = memf(a);
    expIdle(); eOe = 4'b0010; eChk = 1'b1; ePins = {2'b11, d[7], 1'b1};
    eRe = 1'b1; eRa = a + 24'd1;
    step("R7");
    for (int b = 0; b < n; b++) begin
      d = memf(a + 24'(b));
      for (int j = 6; j >= 0; j--) begin
        expIdle(); eOe = 4'b0010; eChk = 1'b1; ePins = {2'b11, d[j], 1'b1};
        step("R7");
      end
      if (b < n - 1) begin
        d = memf(a + 24'(b + 1));
        expIdle(); eOe = 4'b0010; eChk = 1'b1; ePins = {2'b11, d[7], 1'b1};
        eRe = 1'b1; eRa = a + 24'(b + 2);
        step("R6");
      end
    end
  endtask

  task automatic statusRead(input int n);
    sendCmd(8'h05, 4'b0010, 1'b1, {2'b11, STATUS[7], 1'b1}, "R8");
    hostEn = 1'b0;
    for (int b = 0; b < n; b++) begin
      for (int j = 6; j >= 0; j--) begin
        expIdle(); eOe = 4'b0010; eChk = 1'b1; ePins = {2'b11, STATUS[j], 1'b1};
        step("R8");
      end
      if (b < n - 1) begin
        expIdle(); eOe = 4'b0010; eChk = 1'b1; ePins = {2'b11, STATUS[7], 1'b1};
        step("R8");
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    expIdle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expIdle(); eChk = 1'b1;
    step("R1");
    csHigh(1, "R1");

    // R5 quad reads whose last address nibble falls 1111 -> 0000
    quadRead(24'h01FFF0, 8, 1'b0, "R5");
    csHigh(1, "R10");
    quadRead(24'hABCDF0, 5, 1'b0, "R5");
    csHigh(2, "R10");
    // R5 wrap at the top of the address space
    quadRead(24'hFFFFFE, 4, 1'b0, "R5");
    csHigh(2, "R10");

    // R7 single-line read
    singleRead(24'h00123F, 3);
    csHigh(2, "R10");

    // R8 status repetition
    statusRead(2);
    csHigh(2, "R10");

    // R9 unknown opcode, next byte decoded as a new command
    sendCmd(8'h7F, 4'b0000, 1'b1, 4'hF, "R9");
    sendCmd(8'hFF, 4'b0000, 1'b1, 4'hF, "R9");
    csHigh(2, "R9");

    // R10 abort in the middle of the quad address
    sendCmd(8'hEB, 4'b0000, 1'b0, 4'hF, "R2");
    for (int k = 0; k < 3; k++) begin
      hostEn = 1'b1; hostDrv = 4'hF;
      expIdle();
      step("R3");
    end
    csHigh(1, "R10");
    quadRead(24'h01FFF0, 3, 1'b0, "R10");

    // R10 abort in the middle of quad data, then a fresh command
    csHigh(1, "R10");
    quadRead(24'h3456F0, 3, 1'b1, "R5");
    csHigh(1, "R10");
    statusRead(1);
    csHigh(2, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule